// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a scratchpad shared by a group of requesting lanes. Each lane offers one word address per group, with a valid flag, a write enable and write data. Words are interleaved across a power-of-two number of single-port banks. The bank index is the low address bits, so neighbouring words sit in neighbouring banks. The block accepts a whole group in one cycle. It then serves, in every following cycle, one distinct word per bank. Lanes that fall in different banks go through together. Lanes that pick different words of one bank are spread over extra cycles. Lanes that pick the very same word are merged into a single broadcast access.

A requester presents a group while `stall` is low. It then waits for `grp_done`. At that point every valid lane's read result is on `rd_data`. The group occupies the memory for as many cycles as its most heavily loaded bank has distinct words. Within a bank, the lowest-numbered pending lane sets the word served in each cycle. Every other pending lane that asks for that word rides along. Groups never overlap, so one group's requests cannot interact with another's.

Top module: `scp_banked_scratchpad`

## Requirements
- R1: A word address splits into bank = address mod NBANKS (low bits) and row = address / NBANKS (high bits). Words are 32 bits. Builds with 32 banks (default) and with 16 banks are both supported. A word written by one group reads back unchanged in a later group.
- R2: After reset `stall`, `grp_done` and all of `rd_data` are 0. A group is accepted on a rising edge where `stall` is low and at least one `req_valid` bit is set. `stall` is high in the next cycle. While `stall` is high, all request inputs are ignored.
- R3: A group whose valid lanes all map to different banks finishes in one service cycle: `stall` is high for exactly 1 cycle.
- R4: `stall` stays high for exactly k cycles, where k is the largest number of distinct word addresses among the valid lanes that map to any one bank.
- R5: Valid lanes naming the identical word count as one access (broadcast). A group where every lane names one word takes 1 cycle and returns that word to all lanes.
- R6: `grp_done` is high for one cycle, in the first cycle after the last service cycle, which is the cycle in which `stall` is low again. `rd_data` of every valid lane holds its result from then until it is overwritten by a later group.
- R7: A read returns the word's content from before the group. This holds even when another lane of the same group writes that word.
- R8: When several valid lanes of one group write the same word, the lane with the highest index supplies the stored value.
- R9: With lane i addressing base + s·i, the group is conflict-free (1 cycle) when gcd(s, NBANKS) = 1. With 16 banks and 16 lanes, stride 2 takes 2 cycles, stride 4 takes 4 cycles and stride 8 takes 8 cycles. With 32 banks and 32 lanes, stride 8 takes 8 cycles and stride 16 takes 16 cycles.
- R10: A lane with `req_valid` low writes nothing, and its `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; clears memory and state |
| req_valid | input | LANES | Per-lane request valid |
| req_we | input | LANES | Per-lane write enable (1 = write, 0 = read) |
| req_addr | input | LANES × AW | Per-lane word address, AW = log2(NBANKS) + log2(DEPTH) |
| req_wdata | input | LANES × 32 | Per-lane write data |
| rd_data | output | LANES × 32 | Per-lane registered read result |
| grp_done | output | 1 | One-cycle pulse when the accepted group is complete |
| stall | output | 1 | High while any lane of the accepted group is unserved |

## Verification
A group is sampled at edge E0 and served at edges E1..Ek. `stall` is therefore high from just after E0 until just after Ek, and `grp_done` and `rd_data` become valid just after Ek. The bench drives inputs on falling edges. It removes `req_valid` on the falling edge after acceptance and counts falling edges until `grp_done` is seen. That count is compared with the k predicted from the per-bank distinct-address count. Read data is compared at that same falling edge against a word model, which is updated with read-before-write and highest-lane-wins rules. A request presented mid-group is checked through a later read-back group.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // write request one bank receives in a service cycle
    typedef struct packed {
        logic  en;
        word_t data;
    } wr_port_t;

endpackage

// File: rtl/scp_bank_pick.sv
// Per-bank selector: the lowest pending lane mapped here sets the word;
// every pending lane naming that same word is served with it.
module scp_bank_pick import scp_pkg::*; #(
    parameter int LANES   = 32,
    parameter int NBANKS  = 32,
    parameter int DEPTH   = 16,
    parameter int BANK_ID = 0,
    localparam int BW = $clog2(NBANKS),
    localparam int RW = $clog2(DEPTH),
    localparam int AW = BW + RW
) (
    input  logic [LANES-1:0]             pend,
    input  logic [LANES-1:0][AW-1:0]     addr,
    input  logic [LANES-1:0]             we,
    input  logic [LANES-1:0][WORD_W-1:0] wdata,
    output logic [LANES-1:0]             grant,
    output logic [RW-1:0]                row,
    output wr_port_t                     wr
);

    localparam logic [BW-1:0] MY_BANK = BW'(BANK_ID);

    logic          found;
    logic [AW-1:0] lead;

    always_comb begin
        found = 1'b0;
        lead  = '0;
        grant = '0;
        wr    = '0;
        for (int l = 0; l < LANES; l++) begin
            if (!found && pend[l] && addr[l][BW-1:0] == MY_BANK) begin
                found = 1'b1;
                lead  = addr[l];
            end
        end
        // later lanes overwrite earlier ones: highest writer wins
        for (int l = 0; l < LANES; l++) begin
            if (found && pend[l] && addr[l] == lead) begin
                grant[l] = 1'b1;
                if (we[l]) begin
                    wr.en   = 1'b1;
                    wr.data = wdata[l];
                end
            end
        end
    end

    assign row = lead[AW-1:BW];

endmodule

// File: rtl/scp_bank_store.sv
// One bank: single port, combinational read of the addressed row,
// write at the clock edge (reads in that cycle see the old word).
module scp_bank_store import scp_pkg::*; #(
    parameter int DEPTH = 16,
    localparam int RW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] row,
    input  wr_port_t      wr,
    output word_t         rd
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < DEPTH; d++) mem[d] <= '0;
        end else if (wr.en) begin
            mem[row] <= wr.data;
        end
    end

    assign rd = mem[row];

endmodule

// File: rtl/scp_banked_scratchpad.sv
module scp_banked_scratchpad import scp_pkg::*; #(
    parameter int LANES  = 32,
    parameter int NBANKS = 32,
    parameter int DEPTH  = 16,
    localparam int BW = $clog2(NBANKS),
    localparam int RW = $clog2(DEPTH),
    localparam int AW = BW + RW
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [LANES-1:0]             req_valid,
    input  logic [LANES-1:0]             req_we,
    input  logic [LANES-1:0][AW-1:0]     req_addr,
    input  logic [LANES-1:0][WORD_W-1:0] req_wdata,
    output logic [LANES-1:0][WORD_W-1:0] rd_data,
    output logic                         grp_done,
    output logic                         stall
);

    logic [LANES-1:0]             pend_q;
    logic [LANES-1:0]             we_q;
    logic [LANES-1:0][AW-1:0]     addr_q;
    logic [LANES-1:0][WORD_W-1:0] wdata_q;
    logic [LANES-1:0][WORD_W-1:0] rd_q;
    logic                         done_q;

    logic [NBANKS-1:0][LANES-1:0] bank_grant;
    logic [NBANKS-1:0][RW-1:0]    bank_row;
    wr_port_t                     bank_wr [NBANKS];
    word_t                        bank_rd [NBANKS];
    logic [LANES-1:0]             grant_all;
    logic                         busy;
    logic                         accept;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        scp_bank_pick #(
            .LANES(LANES), .NBANKS(NBANKS), .DEPTH(DEPTH), .BANK_ID(b)
        ) u_pick (
            .pend(pend_q), .addr(addr_q), .we(we_q), .wdata(wdata_q),
            .grant(bank_grant[b]), .row(bank_row[b]), .wr(bank_wr[b])
        );
        scp_bank_store #(.DEPTH(DEPTH)) u_store (
            .clk(clk), .rst(rst), .row(bank_row[b]),
            .wr(bank_wr[b]), .rd(bank_rd[b])
        );
    end

    always_comb begin
        grant_all = '0;
        for (int b = 0; b < NBANKS; b++) grant_all |= bank_grant[b];
    end

    assign busy   = |pend_q;
    assign accept = !busy && (|req_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            we_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rd_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= busy && ((pend_q & ~grant_all) == '0);
            if (accept) begin
                pend_q  <= req_valid;
                we_q    <= req_we;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end else begin
                pend_q <= pend_q & ~grant_all;
            end
            for (int l = 0; l < LANES; l++) begin
                if (grant_all[l]) rd_q[l] <= bank_rd[addr_q[l][BW-1:0]];
            end
        end
    end

    assign rd_data  = rd_q;
    assign grp_done = done_q;
    assign stall    = busy;

    // R2: an offered group while idle raises stall in the next cycle
    a_r2_accept_stall: assert property (@(posedge clk) disable iff (rst)
        (!stall && (|req_valid)) |=> stall);

    // R4: every service cycle retires at least one lane
    a_r4_progress: assert property (@(posedge clk) disable iff (rst)
        (|pend_q) |=> ($countones(pend_q) < $countones($past(pend_q))));

    // R6: completion is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        grp_done |=> !grp_done);

    // R6: completion coincides with stall being released
    a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
        grp_done |-> !stall);

endmodule

// File: tb/scp_banked_scratchpad_bench.sv
module scp_banked_scratchpad_bench;

    localparam int L    = 32;
    localparam int AW   = 9;
    localparam int NW   = 512;

    typedef struct packed {
        logic [9:0] stride;
        logic [8:0] base;
        logic [1:0] wmode;   // 0 read, 1 write, 2 even lanes write
        logic       b16;     // run on the 16-bank build
        logic [5:0] kexp;    // expected service cycles
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{10'd1,  9'd0,   2'd1, 1'b0, 6'd1},
        '{10'd1,  9'd0,   2'd0, 1'b0, 6'd1},
        '{10'd2,  9'd64,  2'd1, 1'b0, 6'd2},
        '{10'd2,  9'd64,  2'd0, 1'b0, 6'd2},
        '{10'd3,  9'd0,   2'd0, 1'b0, 6'd1},
        '{10'd8,  9'd200, 2'd2, 1'b0, 6'd8},
        '{10'd16, 9'd1,   2'd0, 1'b0, 6'd16},
        '{10'd0,  9'd9,   2'd0, 1'b0, 6'd1},
        '{10'd33, 9'd0,   2'd0, 1'b0, 6'd1},
        '{10'd2,  9'd0,   2'd0, 1'b1, 6'd2},
        '{10'd8,  9'd3,   2'd0, 1'b1, 6'd8},
        '{10'd1,  9'd5,   2'd0, 1'b1, 6'd1},
        '{10'd4,  9'd0,   2'd0, 1'b1, 6'd4}
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [L-1:0]         vld = '0;
    logic [L-1:0]         we  = '0;
    logic [L-1:0][AW-1:0] addr = '0;
    logic [L-1:0][31:0]   wd  = '0;
    logic                 en16 = 1'b0;

    logic [L-1:0][31:0]   rdd;
    logic                 done, stall;
    logic [15:0][31:0]    rdd16;
    logic                 done16, stall16;

    logic [31:0] mdl [NW];
    logic [31:0] exp_rd [L];
    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;   // 125 MHz

    scp_banked_scratchpad u_scp_banked_scratchpad (
        .clk(clk), .rst(rst),
        .req_valid(en16 ? '0 : vld), .req_we(we), .req_addr(addr),
        .req_wdata(wd), .rd_data(rdd), .grp_done(done), .stall(stall)
    );

    scp_banked_scratchpad #(.LANES(16), .NBANKS(16), .DEPTH(32)) u_scp_b16 (
        .clk(clk), .rst(rst),
        .req_valid(en16 ? vld[15:0] : 16'h0), .req_we(we[15:0]),
        .req_addr(addr[15:0]), .req_wdata(wd[15:0]),
        .rd_data(rdd16), .grp_done(done16), .stall(stall16)
    );

    function automatic logic [31:0] pat(int g, int l);
        return 32'hA500_0001 ^ (32'(g) << 16) ^ (32'(l) * 32'h0000_0101);
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fill(input int base, input int stride, input int wmode, input int g);
        for (int l = 0; l < L; l++) begin
            addr[l] = AW'((base + stride * l) % NW);
            we[l]   = (wmode == 1) || (wmode == 2 && (l % 2) == 0);
            wd[l]   = pat(g, l);
        end
    endtask

    // issue one group; cyc = falling edges from acceptance until grp_done
    task automatic run_group(input logic [L-1:0] mask, input bit on16,
                             input bit poke, output int cyc);
        if (!on16) begin
            for (int l = 0; l < L; l++) if (mask[l]) exp_rd[l] = mdl[addr[l]];
            for (int l = 0; l < L; l++) if (mask[l] && we[l]) mdl[addr[l]] = wd[l];
        end
        @(negedge clk);
        en16 = on16;
        vld  = mask;
        @(posedge clk);
        @(negedge clk);
        vld = '0;
        cyc = 0;
        while (((on16 ? done16 : done) == 1'b0) && cyc < 200) begin
            cyc++;
            if (poke && cyc == 3) begin
                for (int l = 0; l < L; l++) begin
                    we[l] = 1'b1;
                    wd[l] = 32'hDEAD_0000 | 32'(l);
                end
                vld = '1;
            end
            @(negedge clk);
        end
        vld = '0;
    endtask

    task automatic check_data(input logic [L-1:0] mask, input string req);
        for (int l = 0; l < L; l++)
            if (mask[l]) chk(rdd[l] === exp_rd[l], req, rdd[l], exp_rd[l]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog R4: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
        $finish;
    end

    initial begin
        int cyc;
        logic [31:0] keep;
        for (int i = 0; i < NW; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: reset state
        chk(stall == 1'b0, "R2 stall after reset", 32'(stall), 0);
        chk(done == 1'b0, "R2 done after reset", 32'(done), 0);
        chk(rdd == '0, "R2 rd_data after reset", rdd[0], 0);

        // table: R1 R3 R4 R5 R9 patterns on both builds
        for (int i = 0; i < NV; i++) begin
            fill(int'(VECS[i].base), int'(VECS[i].stride), int'(VECS[i].wmode), i);
            run_group(VECS[i].b16 ? 32'h0000_FFFF : 32'hFFFF_FFFF, VECS[i].b16, 1'b0, cyc);
            chk(cyc == int'(VECS[i].kexp), "R3/R4/R5/R9 service cycles",
                32'(cyc), 32'(VECS[i].kexp));
            chk((VECS[i].b16 ? stall16 : stall) == 1'b0, "R6 stall low at done",
                32'(VECS[i].b16 ? stall16 : stall), 0);
            if (!VECS[i].b16) check_data('1, "R1/R5/R7 read data");
        end

        // R8: all lanes write one word, highest lane wins
        fill(300, 0, 1, 40);
        run_group('1, 1'b0, 1'b0, cyc);
        chk(cyc == 1, "R5 merged writes one cycle", 32'(cyc), 1);
        fill(300, 0, 0, 41);
        run_group(32'h1, 1'b0, 1'b0, cyc);
        chk(rdd[0] === pat(40, 31), "R8 highest writer", rdd[0], pat(40, 31));

        // R7: read merged with writes of the same word sees the old value
        fill(77, 0, 0, 42);
        we[0] = 1'b1;
        we[2] = 1'b1;
        mdl[77] = mdl[77];
        run_group(32'h7, 1'b0, 1'b0, cyc);
        chk(cyc == 1, "R5 mixed merge one cycle", 32'(cyc), 1);
        chk(rdd[1] === 32'h0, "R7 read before write", rdd[1], 32'h0);
        fill(77, 0, 0, 43);
        run_group(32'h1, 1'b0, 1'b0, cyc);
        chk(rdd[0] === pat(42, 2), "R8 lane 2 over lane 0", rdd[0], pat(42, 2));

        // R10: invalid lanes write nothing and keep rd_data
        keep = rdd[31];
        fill(400, 1, 1, 44);
        run_group(32'h0000_FFFF, 1'b0, 1'b0, cyc);
        chk(rdd[31] === keep, "R10 invalid lane rd_data held", rdd[31], keep);
        fill(400, 1, 0, 45);
        run_group('1, 1'b0, 1'b0, cyc);
        check_data('1, "R10 invalid lanes wrote nothing");

        // R2: requests offered while stalled are ignored
        fill(1, 16, 0, 46);
        run_group('1, 1'b0, 1'b1, cyc);
        chk(cyc == 16, "R2/R4 busy group cycles", 32'(cyc), 16);
        fill(1, 16, 0, 47);
        run_group('1, 1'b0, 1'b0, cyc);
        check_data('1, "R2 mid-group request ignored");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
        $finish;
    end

endmodule